// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block sits next to a small 8-bit processor core and condenses all interrupt activity into one request line plus a 16-bit vector address. It handles four jobs that the core leaves to external logic. It catches the falling edge of the non-maskable line after synchronising it. It gates the maskable request lines with the interrupt-disable bit that the core exports. It ranks every pending source. It drives the vector address that the core reads during its vector fetch.

Reset is treated as the top-priority source. After reset is released, the reset vector is presented until the core performs its first vector fetch. A software break reuses the vector of maskable line 0. Each extra maskable line gets its own vector below the fixed ones, so a system can run more interrupt sources than the base set of reset, non-maskable and maskable. All vectors are computed from parameters.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high) clears the non-maskable pending flag and arms a reset-pending flag. After release, `int_req` is 0 and `vec_addr` is 16'hFFFC until a cycle with `vec_fetch` high while 16'hFFFC is presented. That fetch clears the reset-pending flag.
- R2: `nmi_line_n` passes through a two-flop synchroniser and an edge detector. A high-to-low transition sets the non-maskable pending flag, which takes effect after the third rising clock edge that samples the low level. A line held low sets the flag once only. A new fall needs the line to return high first.
- R3: The non-maskable pending flag stays set until a clock edge at which `vec_fetch` is high and `vec_addr` is 16'hFFFA. A fetch of any other vector leaves the flag set.
- R4: While the non-maskable flag is pending, `int_req` is 1 whatever `int_mask` is.
- R5: While `int_mask` is 1, the `req_lines` bits neither raise `int_req` nor select a vector.
- R6: Priority: reset-pending first, then non-maskable pending, then break or maskable lines. Among the maskable lines, the lowest index wins.
- R7: Maskable line 0 selects 16'hFFFE. Line N (N ≥ 1) selects 16'hFFF8 − 2·N, giving 16'hFFF6, 16'hFFF4 and 16'hFFF2 for lines 1 to 3. With nothing selected, `vec_addr` rests at 16'hFFFE.
- R8: While `brk_active` is 1 and neither reset nor the non-maskable source is pending, `vec_addr` is 16'hFFFE. This holds even when the mask is set and when other maskable lines are active.
- R9: `int_req` is 1 exactly when the non-maskable flag is pending or some unmasked `req_lines` bit is 1. Reset-pending and break alone leave it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_line_n | input | 1 | Asynchronous non-maskable request, active low, edge sensitive |
| req_lines | input | NUM_IRQ | Level-sensitive maskable requests, bit 0 highest priority |
| int_mask | input | 1 | Interrupt-disable bit exported by the core |
| brk_active | input | 1 | Core is executing a break instruction |
| vec_fetch | input | 1 | Core is reading the vector this cycle |
| int_req | output | 1 | Interrupt request to the core |
| vec_addr | output | 16 | Vector address for the selected source |

## Verification
The bench holds the non-maskable line low well past its service. A level-sensitive design would request service again, and a design that clears the flag on the wrong fetch would keep requesting or would drop a request. The bench samples the request one edge before the synchroniser latency ends, which catches a missing or extra flop. It sets the mask with a high-index line active, so leaking masked requests show up as a wrong vector. It raises break while other lines are active to show that break always returns the line 0 vector. It creates a pending non-maskable edge while reset-pending is still set, which checks the ranking and that a reset-vector fetch leaves the non-maskable flag alone.

// File: rtl/vic_pkg.sv
package vic_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_RST  = 2'd1,
      SRC_NMI  = 2'd2,
      SRC_MASK = 2'd3
   } src_kind_e;
endpackage

// File: rtl/vic_nmi_detect.sv
module vic_nmi_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_n,
   input  logic clr,
   output logic fall,
   output logic pend
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("vic_nmi_detect: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   pend_q;
   logic                   synced;

   always_ff @(posedge clk) begin
      if (rst) sync_q <= '1;
      else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_n};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= synced;
   end

   assign fall = prev_q & ~synced;

   // a fresh edge wins over a same-cycle service
   always_ff @(posedge clk) begin
      if (rst) pend_q <= 1'b0;
      else     pend_q <= fall | (pend_q & ~clr);
   end

   assign pend = pend_q;
endmodule

// File: rtl/vic_prio.sv
module vic_prio
   import vic_pkg::*;
#(
   parameter int NUM_IRQ = 4,
   parameter int IDX_W   = 2
) (
   input  logic               rst_pend,
   input  logic               nmi_pend,
   input  logic               brk,
   input  logic [NUM_IRQ-1:0] lines,
   input  logic               mask,
   output src_kind_e          kind,
   output logic [IDX_W-1:0]   idx,
   output logic               req
);
   logic [NUM_IRQ-1:0] gated;
   logic [IDX_W-1:0]   win;
   logic               any;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_gate
      assign gated[i] = lines[i] & ~mask;
   end

   always_comb begin
      win = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (gated[i]) win = IDX_W'(i);
      end
   end

   assign any = |gated;

   always_comb begin
      kind = SRC_NONE;
      idx  = '0;
      if (rst_pend) begin
         kind = SRC_RST;
      end else if (nmi_pend) begin
         kind = SRC_NMI;
      end else if (brk) begin
         kind = SRC_MASK;
      end else if (any) begin
         kind = SRC_MASK;
         idx  = win;
      end
   end

   assign req = nmi_pend | any;
endmodule

// File: rtl/vic_vec_gen.sv
module vic_vec_gen
   import vic_pkg::*;
#(
   parameter int                NUM_IRQ  = 4,
   parameter int                IDX_W    = 2,
   parameter int                VEC_W    = 16,
   parameter logic [VEC_W-1:0]  RST_VEC  = 16'hFFFC,
   parameter logic [VEC_W-1:0]  NMI_VEC  = 16'hFFFA,
   parameter logic [VEC_W-1:0]  IRQ_VEC  = 16'hFFFE,
   parameter logic [VEC_W-1:0]  EXT_BASE = 16'hFFF8
) (
   input  src_kind_e         kind,
   input  logic [IDX_W-1:0]  idx,
   output logic [VEC_W-1:0]  vec
);
   logic [VEC_W-1:0] tbl [NUM_IRQ];
   logic [VEC_W-1:0] line_vec;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_tbl
      if (i == 0) begin : g_base
         assign tbl[i] = IRQ_VEC;
      end else begin : g_ext
         localparam logic [VEC_W-1:0] STEP = VEC_W'(2 * i);
         assign tbl[i] = EXT_BASE - STEP;
      end
   end

   always_comb begin
      line_vec = tbl[0];
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (idx == IDX_W'(i)) line_vec = tbl[i];
      end
   end

   always_comb begin
      unique case (kind)
         SRC_RST:  vec = RST_VEC;
         SRC_NMI:  vec = NMI_VEC;
         SRC_MASK: vec = line_vec;
         default:  vec = IRQ_VEC;
      endcase
   end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int                NUM_IRQ     = 4,
   parameter int                SYNC_STAGES = 2,
   parameter int                VEC_W       = 16,
   parameter logic [VEC_W-1:0]  RST_VEC     = 16'hFFFC,
   parameter logic [VEC_W-1:0]  NMI_VEC     = 16'hFFFA,
   parameter logic [VEC_W-1:0]  IRQ_VEC     = 16'hFFFE,
   parameter logic [VEC_W-1:0]  EXT_BASE    = 16'hFFF8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               nmi_line_n,
   input  logic [NUM_IRQ-1:0] req_lines,
   input  logic               int_mask,
   input  logic               brk_active,
   input  logic               vec_fetch,
   output logic               int_req,
   output logic [VEC_W-1:0]   vec_addr
);
   localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

   if (NUM_IRQ < 1 || NUM_IRQ > 32) begin : g_bad_num
      $error("vec_irq_ctrl: NUM_IRQ must be within 1..32");
   end
   if (VEC_W < 8) begin : g_bad_width
      $error("vec_irq_ctrl: VEC_W too narrow");
   end

   logic             rst_pend;
   logic             nmi_pend;
   logic             nmi_fall;
   logic             nmi_clr;
   src_kind_e        kind;
   logic [IDX_W-1:0] idx;

   assign nmi_clr = vec_fetch & (kind == SRC_NMI);

   always_ff @(posedge clk) begin
      if (rst)                                rst_pend <= 1'b1;
      else if (vec_fetch && kind == SRC_RST)  rst_pend <= 1'b0;
   end

   vic_nmi_detect #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
      .clk    (clk),
      .rst    (rst),
      .line_n (nmi_line_n),
      .clr    (nmi_clr),
      .fall   (nmi_fall),
      .pend   (nmi_pend)
   );

   vic_prio #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_prio (
      .rst_pend (rst_pend),
      .nmi_pend (nmi_pend),
      .brk      (brk_active),
      .lines    (req_lines),
      .mask     (int_mask),
      .kind     (kind),
      .idx      (idx),
      .req      (int_req)
   );

   vic_vec_gen #(
      .NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W), .VEC_W(VEC_W),
      .RST_VEC(RST_VEC), .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC),
      .EXT_BASE(EXT_BASE)
   ) u_vec (
      .kind (kind),
      .idx  (idx),
      .vec  (vec_addr)
   );
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
   parameter int                VEC_W   = 16,
   parameter logic [VEC_W-1:0]  RST_VEC = 16'hFFFC,
   parameter logic [VEC_W-1:0]  NMI_VEC = 16'hFFFA,
   parameter logic [VEC_W-1:0]  IRQ_VEC = 16'hFFFE
) (
   input logic             clk,
   input logic             rst,
   input logic             nmi_line_n,
   input logic             int_mask,
   input logic             brk_active,
   input logic             vec_fetch,
   input logic             int_req,
   input logic [VEC_W-1:0] vec_addr,
   input logic             nmi_pend,
   input logic             nmi_fall,
   input logic             rst_pend
);
   a_r1_reset_vector: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (vec_addr == RST_VEC && !int_req));

   a_r2_nmi_needs_low: assert property (@(posedge clk) disable iff (rst)
      $rose(nmi_pend) |-> ($past(nmi_line_n, 2) == 1'b0));

   a_r3_nmi_served: assert property (@(posedge clk) disable iff (rst)
      (vec_fetch && vec_addr == NMI_VEC && !nmi_fall) |=> !nmi_pend);

   a_r3_nmi_held: assert property (@(posedge clk) disable iff (rst)
      (nmi_pend && vec_addr != NMI_VEC) |=> nmi_pend);

   a_r4_nmi_unmasked: assert property (@(posedge clk) disable iff (rst)
      nmi_pend |-> int_req);

   a_r5_mask_blocks: assert property (@(posedge clk) disable iff (rst)
      (int_mask && !nmi_pend) |-> !int_req);

   a_r6_rst_first: assert property (@(posedge clk) disable iff (rst)
      rst_pend |-> (vec_addr == RST_VEC));

   a_r8_brk_vector: assert property (@(posedge clk) disable iff (rst)
      (brk_active && !rst_pend && !nmi_pend) |-> (vec_addr == IRQ_VEC));
endmodule

bind vec_irq_ctrl vic_checker #(
   .VEC_W(VEC_W), .RST_VEC(RST_VEC), .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .nmi_line_n (nmi_line_n),
   .int_mask   (int_mask),
   .brk_active (brk_active),
   .vec_fetch  (vec_fetch),
   .int_req    (int_req),
   .vec_addr   (vec_addr),
   .nmi_pend   (nmi_pend),
   .nmi_fall   (nmi_fall),
   .rst_pend   (rst_pend)
);

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/100ps
module vec_irq_ctrl_tb;
   typedef struct {
      logic        irq;
      logic [15:0] vec;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        nmi_line_n = 1'b1;
   logic [3:0]  req_lines = '0;
   logic        int_mask = 1'b0;
   logic        brk_active = 1'b0;
   logic        vec_fetch = 1'b0;
   logic        int_req;
   logic [15:0] vec_addr;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   vec_irq_ctrl u_dut (
      .clk(clk), .rst(rst), .nmi_line_n(nmi_line_n), .req_lines(req_lines),
      .int_mask(int_mask), .brk_active(brk_active), .vec_fetch(vec_fetch),
      .int_req(int_req), .vec_addr(vec_addr)
   );

   // monitor: compares queued expectations mid-cycle
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_chk++;
         if (int_req !== e.irq || vec_addr !== e.vec) begin
            n_bad++;
            $display("FAIL %s: got int_req=%0b vec=%h, expected int_req=%0b vec=%h",
                     e.tag, int_req, vec_addr, e.irq, e.vec);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input logic irq, input logic [15:0] vec, input string tag);
      exp_t e;
      e.irq = irq; e.vec = vec; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic fetch();
      vec_fetch = 1'b1;
      step(1);
      vec_fetch = 1'b0;
   endtask

   initial begin
      repeat (4000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      step(3);
      rst = 1'b0;
      expect_out(1'b0, 16'hFFFC, "R1 reset vector after release");
      step(2);
      // non-maskable edge while reset still pending
      nmi_line_n = 1'b0;
      step(3);
      expect_out(1'b1, 16'hFFFC, "R6 reset outranks pending NMI");
      step(1);
      fetch();
      expect_out(1'b1, 16'hFFFA, "R3 reset fetch leaves NMI pending");
      fetch();
      expect_out(1'b0, 16'hFFFE, "R3 NMI cleared by its own fetch");
      step(10);
      expect_out(1'b0, 16'hFFFE, "R2 held-low line does not retrigger");
      step(1);

      // maskable lines
      req_lines = 4'b0001;
      expect_out(1'b1, 16'hFFFE, "R7 line 0 vector");
      step(1);
      req_lines = 4'b0100;
      expect_out(1'b1, 16'hFFF4, "R7 line 2 vector");
      step(1);
      req_lines = 4'b1000;
      expect_out(1'b1, 16'hFFF2, "R7 line 3 vector");
      step(1);
      req_lines = 4'b1010;
      expect_out(1'b1, 16'hFFF6, "R6 lowest line index wins");
      step(1);
      int_mask = 1'b1;
      req_lines = 4'b0100;
      expect_out(1'b0, 16'hFFFE, "R5 masked line ignored");
      step(1);
      brk_active = 1'b1;
      expect_out(1'b0, 16'hFFFE, "R8 break vector under mask");
      step(1);
      int_mask = 1'b0;
      expect_out(1'b1, 16'hFFFE, "R8 break beats line 2");
      step(1);
      brk_active = 1'b0;
      req_lines = 4'b0000;
      expect_out(1'b0, 16'hFFFE, "R9 idle, no request");
      step(1);

      // re-arm and fresh edge under mask
      nmi_line_n = 1'b1;
      step(4);
      int_mask = 1'b1;
      req_lines = 4'b0010;
      nmi_line_n = 1'b0;
      step(2);
      expect_out(1'b0, 16'hFFFE, "R2 not pending before third edge");
      step(1);
      expect_out(1'b1, 16'hFFFA, "R4 NMI requests despite mask");
      step(5);
      brk_active = 1'b1;
      int_mask = 1'b0;
      expect_out(1'b1, 16'hFFFA, "R6 NMI outranks break and lines");
      step(1);
      brk_active = 1'b0;
      fetch();
      expect_out(1'b1, 16'hFFF6, "R3 after service line 1 shows");
      step(1);

      // reset mid-run clears state
      req_lines = 4'b0000;
      nmi_line_n = 1'b1;
      step(4);
      nmi_line_n = 1'b0;
      step(4);
      expect_out(1'b1, 16'hFFFA, "R2 second fall pending");
      nmi_line_n = 1'b1;
      rst = 1'b1;
      step(2);
      rst = 1'b0;
      expect_out(1'b0, 16'hFFFC, "R1 reset drops pending NMI");
      step(1);
      fetch();
      expect_out(1'b0, 16'hFFFE, "R1 reset vector fetched and cleared");
      step(2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule